// File: doc/BRIEF.md
# Synchronous clock stop and gating

The block takes two source clocks, one feeding a group of single-ended PCI outputs and one feeding several differential CPU pairs. It gates each output according to two active-low stop pins, a per-output enable bit, and a per-output choice between free-running and stoppable. Each gate changes only while its output already sits at its rest level. A PCI output therefore always stops low after a complete high phase. A CPU pair always stops with true high and complement low after a complete true-high phase. A restart always begins with a full-width pulse.

Both stop pins are asynchronous. Each passes through a two-flop synchroniser in the domain it controls before any gate uses it. The enable and stoppable bits are quasi-static register bits. The gate flops sample them directly. An asynchronous power-down pin overrides everything: all outputs go low and both outputs of every CPU pair stop being driven.

Top module: `clk_stop_gate`

## Requirements
- R1: While rst_n is low, every PCI and free-running-capable PCI output is low, every CPU true output is high and every complement output is low, with all output enables at 1 (power-down released).
- R2: pci_stop_n driven low during the low phase of PCI source cycle k leaves the high phase of cycle k+2 complete. From cycle k+3 on, every PCI output stays low.
- R3: pci_stop_n returned high during the low phase of cycle k keeps the PCI outputs low through cycle k+2. They restart with a full high phase in cycle k+3.
- R4: A PCI_F output whose stoppable bit is 0 keeps toggling while pci_stop_n is low. One whose bit is 1 stops on the same cycle as the PCI outputs.
- R5: Clearing a single-ended enable bit during the low phase of cycle k leaves the high phase of cycle k+1 intact. That output is low from the high phase of cycle k+2; setting the bit again restores it with the same timing.
- R6: cpu_stop_n driven low during the low phase of CPU source cycle k leaves stoppable pairs running through the low phase of cycle k+2. From the low phase of cycle k+3 they rest with true = 1 and complement = 0.
- R7: A CPU pair whose stoppable bit is 0 ignores cpu_stop_n.
- R8: Clearing a CPU pair's enable bit during the low phase of cycle k makes that pair rest with true = 1 and complement = 0 from the low phase of cycle k+1.
- R9: cpu_stop_n returned high during the low phase of cycle k keeps stopped pairs at rest through the low phase of cycle k+2. They run again from the low phase of cycle k+3, and the next true-high phase is full width.
- R10: While pd_n is high, the true and complement outputs of a pair are never equal.
- R11: While pd_n is low, every output is low and both output-enable vectors of the CPU pairs are 0. When pd_n rises, the outputs resume from the gate state, which power-down does not alter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pci | input | 1 | Source clock of the single-ended group |
| clk_cpu | input | 1 | Source clock of the CPU pairs |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down |
| pci_stop_n | input | 1 | Asynchronous active-low stop for the PCI group |
| cpu_stop_n | input | 1 | Asynchronous active-low stop for the CPU pairs |
| pci_en | input | N_PCI | Enable per PCI output, 1 = enabled |
| pcif_en | input | N_PCIF | Enable per PCI_F output, 1 = enabled |
| pcif_stoppable | input | N_PCIF | 1 = PCI_F output obeys pci_stop_n, 0 = free-running |
| cpu_en | input | N_CPU | Enable per CPU pair, 1 = enabled |
| cpu_stoppable | input | N_CPU | 1 = pair obeys cpu_stop_n, 0 = free-running |
| pci_clk | output | N_PCI | Gated PCI clocks |
| pcif_clk | output | N_PCIF | Gated PCI_F clocks |
| cpu_t | output | N_CPU | True outputs of the CPU pairs |
| cpu_c | output | N_CPU | Complement outputs of the CPU pairs |
| cpu_t_oe | output | N_CPU | Drive enable of the true outputs |
| cpu_c_oe | output | N_CPU | Drive enable of the complement outputs |

## Verification
Two events can fall in the same cycle. The first case is a CPU stop together with an enable bit being cleared. The bench lowers cpu_stop_n and clears one pair's enable in the same low phase. It then expects the disabled pair at rest one cycle later, the stoppable pair at rest three cycles later, and the free-running pair untouched. After the stop is released, the disabled pair must stay at rest. The second case is power-down arriving while pairs are stopped. The bench checks that every output falls to low and undriven at once, and that the previous stopped or running pattern returns when pd_n rises.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3,
  parameter int N_CPU  = 3
) (
  input  logic              clk_pci,
  input  logic              clk_cpu,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              pci_stop_n,
  input  logic              cpu_stop_n,
  input  logic [N_PCI-1:0]  pci_en,
  input  logic [N_PCIF-1:0] pcif_en,
  input  logic [N_PCIF-1:0] pcif_stoppable,
  input  logic [N_CPU-1:0]  cpu_en,
  input  logic [N_CPU-1:0]  cpu_stoppable,
  output logic [N_PCI-1:0]  pci_clk,
  output logic [N_PCIF-1:0] pcif_clk,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_c,
  output logic [N_CPU-1:0]  cpu_t_oe,
  output logic [N_CPU-1:0]  cpu_c_oe
);

  logic [1:0]        psync, csync;
  logic              pci_halt, cpu_halt;
  logic [N_PCI-1:0]  pci_run;
  logic [N_PCIF-1:0] pcif_run;
  logic [N_CPU-1:0]  cpu_run;

  always_ff @(posedge clk_pci or negedge rst_n)
    if (!rst_n) psync <= 2'b11;
    else        psync <= {psync[0], pci_stop_n};

  always_ff @(posedge clk_cpu or negedge rst_n)
    if (!rst_n) csync <= 2'b11;
    else        csync <= {csync[0], cpu_stop_n};

  assign pci_halt = ~psync[1];
  assign cpu_halt = ~csync[1];

  // single-ended gates move only while the source is low
  always_ff @(negedge clk_pci or negedge rst_n)
    if (!rst_n) begin
      pci_run  <= '0;
      pcif_run <= '0;
    end else begin
      pci_run  <= pci_en & {N_PCI{~pci_halt}};
      pcif_run <= pcif_en & ~(pcif_stoppable & {N_PCIF{pci_halt}});
    end

  // differential gates move only while the source is high
  always_ff @(posedge clk_cpu or negedge rst_n)
    if (!rst_n) cpu_run <= '0;
    else        cpu_run <= cpu_en & ~(cpu_stoppable & {N_CPU{cpu_halt}});

  assign pci_clk  = {N_PCI{clk_pci & pd_n}} & pci_run;
  assign pcif_clk = {N_PCIF{clk_pci & pd_n}} & pcif_run;
  assign cpu_t    = {N_CPU{pd_n}} & ({N_CPU{clk_cpu}} | ~cpu_run);
  assign cpu_c    = {N_CPU{pd_n & ~clk_cpu}} & cpu_run;
  assign cpu_t_oe = {N_CPU{pd_n}};
  assign cpu_c_oe = {N_CPU{pd_n}};

  // R2
  pci_sync_delay_chk: assert property (@(posedge clk_pci) disable iff (!rst_n)
    $fell(psync[1]) |-> $past(!pci_stop_n, 2));

  // R11
  pd_float_chk: assert property (@(negedge clk_cpu) disable iff (!rst_n)
    !pd_n |-> (cpu_t == '0 && cpu_c == '0 && cpu_t_oe == '0 && cpu_c_oe == '0));

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci_chk
    // R5
    pci_gate_chk: assert property (@(negedge clk_pci) disable iff (!rst_n)
      pci_clk[i] |-> $past(pci_en[i] && psync[1]));
  end

  for (genvar i = 0; i < N_PCIF; i++) begin : g_pcif_chk
    // R4
    pcif_gate_chk: assert property (@(negedge clk_pci) disable iff (!rst_n)
      pcif_clk[i] |-> $past(pcif_en[i] && !(pcif_stoppable[i] && !psync[1])));
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_chk
    // R6
    cpu_gate_chk: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      cpu_c[i] |-> $past(cpu_en[i] && !(cpu_stoppable[i] && !csync[1])));
    // R10
    cpu_pair_chk: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      pd_n |-> (cpu_t[i] != cpu_c[i]));
  end

endmodule

// File: tb/tb_clk_stop_gate.sv
`timescale 1ns/100ps
module tb_clk_stop_gate;
  logic clk = 0, rst_n = 0, pd_n = 1, pci_stop_n = 1, cpu_stop_n = 1;
  logic [6:0] pci_en = 7'h7f;
  logic [2:0] pcif_en = 3'b111, pcif_stoppable = 3'b001;
  logic [2:0] cpu_en = 3'b111, cpu_stoppable = 3'b011;
  logic [6:0] pci_clk;
  logic [2:0] pcif_clk, cpu_t, cpu_c, cpu_t_oe, cpu_c_oe;

  clk_stop_gate dut (
    .clk_pci(clk), .clk_cpu(clk), .rst_n(rst_n), .pd_n(pd_n),
    .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n),
    .pci_en(pci_en), .pcif_en(pcif_en), .pcif_stoppable(pcif_stoppable),
    .cpu_en(cpu_en), .cpu_stoppable(cpu_stoppable),
    .pci_clk(pci_clk), .pcif_clk(pcif_clk), .cpu_t(cpu_t), .cpu_c(cpu_c),
    .cpu_t_oe(cpu_t_oe), .cpu_c_oe(cpu_c_oe));

  always #2 clk = ~clk;

  typedef struct { int ph; logic [21:0] v; logic [21:0] m; string r; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  function automatic logic [21:0] vec(logic [6:0] p, logic [2:0] f, logic [2:0] t,
                                      logic [2:0] c, logic [2:0] to, logic [2:0] co);
    return {co, to, c, t, f, p};
  endfunction

  localparam logic [21:0] M_PCI = {15'd0, 7'h7f};
  localparam logic [21:0] M_PF  = {12'd0, 3'b111, 7'd0};
  localparam logic [21:0] M_CPU = {6'd0, 6'h3f, 10'd0};
  localparam logic [21:0] M_ALL = 22'h3fffff;

  function automatic logic [21:0] outs();
    return {cpu_c_oe, cpu_t_oe, cpu_c, cpu_t, pcif_clk, pci_clk};
  endfunction

  task automatic check(logic [21:0] act, logic [21:0] exp, logic [21:0] m, string r);
    checks++;
    if ((act & m) !== (exp & m)) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (mask %h)", r, act & m, exp & m, m);
    end
  endtask

  task automatic push(int ph, logic [21:0] v, logic [21:0] m, string r);
    item_t it;
    it.ph = ph; it.v = v; it.m = m; it.r = r;
    q.push_back(it);
  endtask

  task automatic sample(int ph);
    while (q.size() > 0 && q[0].ph <= ph) begin
      if (q[0].ph < ph) begin
        checks++; fails++;
        $display("FAIL %s: actual missed phase %0d expected phase %0d", q[0].r, ph, q[0].ph);
      end else check(outs(), q[0].v, q[0].m, q[0].r);
      void'(q.pop_front());
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #1; sample(2 * cyc);
      @(negedge clk); #1; sample(2 * cyc + 1);
    end
  end

  function automatic int H(int c); return 2 * c; endfunction
  function automatic int L(int c); return 2 * c + 1; endfunction

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1.5; end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int k;
    step(3);
    // R1 reset state, high and low phase
    @(posedge clk); #1;
    check(outs(), vec(7'h00, 3'b000, 3'b111, 3'b000, 3'b111, 3'b111), M_ALL, "R1 high");
    @(negedge clk); #1;
    check(outs(), vec(7'h00, 3'b000, 3'b111, 3'b000, 3'b111, 3'b111), M_ALL, "R1 low");
    step(1); rst_n = 1;
    step(4);

    k = cyc;  // free running baseline
    push(H(k + 1), vec(7'h7f, 3'b111, 3'b111, 3'b000, 3'b111, 3'b111), M_ALL, "R10 run high");
    push(L(k + 1), vec(7'h00, 3'b000, 3'b000, 3'b111, 3'b111, 3'b111), M_ALL, "R10 run low");
    step(3);

    // R2 / R4: PCI stop, F0 stoppable, F1,F2 free
    pci_stop_n = 0; k = cyc;
    push(H(k + 2), vec(7'h7f, 3'b111, 0, 0, 0, 0), M_PCI | M_PF, "R2 last pulse");
    push(H(k + 3), vec(7'h00, 3'b110, 0, 0, 0, 0), M_PCI | M_PF, "R2 R4 stopped");
    push(L(k + 3), vec(0, 0, 3'b000, 3'b111, 0, 0), M_CPU, "R7 cpu ignores pci stop");
    push(H(k + 5), vec(7'h00, 3'b110, 0, 0, 0, 0), M_PCI | M_PF, "R2 stays low");
    step(7);
    // R3 release
    pci_stop_n = 1; k = cyc;
    push(H(k + 2), vec(7'h00, 3'b110, 0, 0, 0, 0), M_PCI | M_PF, "R3 still low");
    push(H(k + 3), vec(7'h7f, 3'b111, 0, 0, 0, 0), M_PCI | M_PF, "R3 full restart");
    step(6);

    // R4 stoppable flipped: F2 stoppable only
    pcif_stoppable = 3'b100; step(3);
    pci_stop_n = 0; k = cyc;
    push(H(k + 3), vec(7'h00, 3'b011, 0, 0, 0, 0), M_PCI | M_PF, "R4 f2 stops");
    step(6); pci_stop_n = 1; step(6);

    // R5 enables
    pci_en = 7'h55; pcif_en = 3'b011; k = cyc;
    push(H(k + 1), vec(7'h7f, 3'b111, 0, 0, 0, 0), M_PCI | M_PF, "R5 old pulse");
    push(H(k + 2), vec(7'h55, 3'b011, 0, 0, 0, 0), M_PCI | M_PF, "R5 disabled low");
    step(5);
    pci_en = 7'h7f; pcif_en = 3'b111; k = cyc;
    push(H(k + 2), vec(7'h7f, 3'b111, 0, 0, 0, 0), M_PCI | M_PF, "R5 re-enabled");
    step(5);

    // R6 / R7 CPU stop, pair2 free-running
    cpu_stop_n = 0; k = cyc;
    push(L(k + 2), vec(0, 0, 3'b000, 3'b111, 0, 0), M_CPU, "R6 still running");
    push(H(k + 3), vec(0, 0, 3'b111, 3'b000, 0, 0), M_CPU, "R6 high phase");
    push(L(k + 3), vec(0, 0, 3'b011, 3'b100, 0, 0), M_CPU, "R6 R7 rest");
    push(L(k + 6), vec(0, 0, 3'b011, 3'b100, 0, 0), M_CPU, "R6 stays at rest");
    step(8);
    // R9 release
    cpu_stop_n = 1; k = cyc;
    push(L(k + 2), vec(0, 0, 3'b011, 3'b100, 0, 0), M_CPU, "R9 still resting");
    push(L(k + 3), vec(0, 0, 3'b000, 3'b111, 0, 0), M_CPU, "R9 running");
    push(H(k + 4), vec(0, 0, 3'b111, 3'b000, 0, 0), M_CPU, "R9 full true pulse");
    step(6);

    // R8 CPU enable
    cpu_en = 3'b101; k = cyc;
    push(L(k + 1), vec(0, 0, 3'b010, 3'b101, 0, 0), M_CPU, "R8 pair1 rest");
    step(4);
    cpu_en = 3'b111; k = cyc;
    push(L(k + 1), vec(0, 0, 3'b000, 3'b111, 0, 0), M_CPU, "R8 pair1 back");
    step(4);

    // R6 / R8 same cycle: stop plus pair0 disabled
    cpu_stop_n = 0; cpu_en = 3'b110; k = cyc;
    push(L(k + 1), vec(0, 0, 3'b001, 3'b110, 0, 0), M_CPU, "R8 same-cycle disable");
    push(L(k + 2), vec(0, 0, 3'b001, 3'b110, 0, 0), M_CPU, "R6 same-cycle pending");
    push(L(k + 3), vec(0, 0, 3'b011, 3'b100, 0, 0), M_CPU, "R6 same-cycle stopped");
    step(6);

    // R11 power-down while pairs stopped
    pd_n = 0; k = cyc;
    push(H(k + 1), 22'd0, M_ALL, "R11 pd high phase");
    push(L(k + 1), 22'd0, M_ALL, "R11 pd low phase");
    step(4);
    pd_n = 1; k = cyc;
    push(H(k + 1), vec(7'h7f, 3'b111, 3'b111, 3'b000, 3'b111, 3'b111), M_ALL, "R11 resume high");
    push(L(k + 1), vec(7'h00, 3'b000, 3'b011, 3'b100, 3'b111, 3'b111), M_ALL, "R11 resume low");
    step(4);

    cpu_stop_n = 1; k = cyc;
    push(L(k + 3), vec(0, 0, 3'b001, 3'b110, 0, 0), M_CPU, "R8 disabled pair stays");
    step(6);
    cpu_en = 3'b111; step(4);

    wait (q.size() == 0);
    step(2);
    summary();
  end
endmodule